// File: doc/BRIEF.md
# Decoded Johnson Decade Counter

This block divides its clock by ten. Its count state lives in a five-stage twisted-ring (Johnson) shift register. The inverted top bit of the ring feeds back into the bottom bit, so the ring steps through ten codes per revolution. Ten decoded lines come out of the block, and exactly one of them is high in each legal count. Each line is a two-input AND of two adjacent ring bits. Only one ring bit changes per step, so the decoded lines do not glitch. A carry line is high for the first half of the revolution and low for the second half, which gives a symmetric divide-by-ten waveform.

An active-high inhibit input freezes the count at the clock edge. An active-low asynchronous reset forces count zero and overrides both the clock and the inhibit. The ring can hold a code outside the legal set, for example after an upset. Recovery logic detects such a code and returns the ring to count zero on the next enabled edge. This keeps the counter from locking into a parasitic loop.

Top module: `jdc_decade_counter`

## Requirements
- R1: While rst_ni is low, dec_o is 10'h001 and carry_o is 1. This takes effect without a clock edge and overrides inhibit_i.
- R2: At a rising edge with inhibit_i high, the ring state is unchanged. This holds for illegal codes as well as legal ones.
- R3: At a rising edge with inhibit_i low and a legal state, the high decoded line moves from bit k to bit k+1. Bit 9 wraps to bit 0.
- R4: In every legal state exactly one bit of dec_o is high. Bit k of dec_o corresponds to count k. Counts advance by one per enabled clock from count 0 after reset, so each line stays high for one enabled clock.
- R5: carry_o is 1 for counts 0 to 4 and 0 for counts 5 to 9. In any state, legal or illegal, carry_o is the inverse of ring bit 4, the top bit.
- R6: The legal ring codes, written bit 4 down to bit 0 and in count order 0 to 9, are 00000, 00001, 00011, 00111, 01111, 11111, 11110, 11100, 11000, 10000. The other 22 codes are illegal.
- R7: At a rising edge with inhibit_i low and an illegal ring code, the ring goes to count zero: dec_o is 10'h001 and carry_o is 1. This meets the bound of five enabled clocks in a single clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Counting clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset to count zero, active low |
| inhibit_i | input | 1 | High holds the count at the clock edge |
| dec_o | output | 10 | Decoded count lines, one-hot in legal states |
| carry_o | output | 1 | High for counts 0 to 4, low for counts 5 to 9 |

## Verification
Two functions can act at the same rising edge: illegal-code recovery and the inhibit hold. Each of the 22 illegal codes is forced into the ring with inhibit high for one edge. The bench then expects the code to be held, with carry equal to the inverted top bit and the decoded lines frozen. On the following edge inhibit is dropped, and the bench expects count zero at once. Reset and counting also meet: reset is asserted between edges while inhibit is low, and the bench expects dec_o to show count zero before the next edge.

// File: rtl/jdc_pkg.sv
`timescale 1ns/1ps
package jdc_pkg;
  parameter int unsigned JdcStages = 5;

  function automatic int unsigned jdc_outs(input int unsigned stages);
    return 2 * stages;
  endfunction
endpackage

// File: rtl/jdc_ring.sv
`timescale 1ns/1ps
module jdc_ring #(
  parameter int unsigned Stages = jdc_pkg::JdcStages
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              inhibit_i,
  output logic [Stages-1:0] ring_o,
  output logic              legal_o
);
  logic [Stages-1:0] ring_q, ring_d;
  logic [Stages-2:0] edge_w;
  int unsigned       n_edges;

  // a legal Johnson code has at most one 0/1 boundary between adjacent bits
  for (genvar i = 0; i < Stages - 1; i++) begin : g_edge
    assign edge_w[i] = ring_q[i] ^ ring_q[i+1];
  end

  always_comb begin
    n_edges = 0;
    for (int i = 0; i < Stages - 1; i++) n_edges += {31'd0, edge_w[i]};
  end

  assign legal_o = (n_edges <= 1);

  always_comb begin
    ring_d = ring_q;
    if (!inhibit_i) ring_d = legal_o ? {ring_q[Stages-2:0], ~ring_q[Stages-1]} : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ring_q <= '0;
    else         ring_q <= ring_d;
  end

  assign ring_o = ring_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && $past(inhibit_i)) |-> $stable(ring_q));

  p_closed_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (legal_o && !inhibit_i) |=> legal_o);

  p_recover_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!legal_o && !inhibit_i) |=> (legal_o && ring_q == '0));
endmodule

// File: rtl/jdc_decode.sv
`timescale 1ns/1ps
module jdc_decode #(
  parameter int unsigned Stages = jdc_pkg::JdcStages,
  localparam int unsigned Outs  = 2 * Stages
) (
  input  logic [Stages-1:0] ring_i,
  output logic [Outs-1:0]   dec_o,
  output logic              carry_o
);
  // each line looks only at the boundary between two adjacent ring bits
  for (genvar k = 0; k < Outs; k++) begin : g_dec
    if (k == 0) begin : g_zero
      assign dec_o[k] = ~ring_i[Stages-1] & ~ring_i[0];
    end else if (k < Stages) begin : g_fill
      assign dec_o[k] = ring_i[k-1] & ~ring_i[k];
    end else if (k == Stages) begin : g_full
      assign dec_o[k] = ring_i[Stages-1] & ring_i[0];
    end else begin : g_drain
      assign dec_o[k] = ~ring_i[k-Stages-1] & ring_i[k-Stages];
    end
  end

  assign carry_o = ~ring_i[Stages-1];
endmodule

// File: rtl/jdc_decade_counter.sv
`timescale 1ns/1ps
module jdc_decade_counter #(
  parameter int unsigned Stages = jdc_pkg::JdcStages,
  localparam int unsigned Outs  = 2 * Stages
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            inhibit_i,
  output logic [Outs-1:0] dec_o,
  output logic            carry_o
);
  logic [Stages-1:0] ring_w;
  logic              legal_w;

  jdc_ring #(.Stages(Stages)) u_ring (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .inhibit_i(inhibit_i),
    .ring_o   (ring_w),
    .legal_o  (legal_w)
  );

  jdc_decode #(.Stages(Stages)) u_dec (
    .ring_i (ring_w),
    .dec_o  (dec_o),
    .carry_o(carry_o)
  );

  p_reset_r1: assert property (@(posedge clk_i)
    !rst_ni |-> (dec_o == Outs'(1) && carry_o));

  p_advance_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(rst_ni) && !$past(inhibit_i) && $past(legal_w))
      |-> dec_o == {$past(dec_o[Outs-2:0]), $past(dec_o[Outs-1])});

  p_onehot_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_w |-> $onehot(dec_o));

  p_carry_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    legal_w |-> (carry_o == (|dec_o[Stages-1:0])));
endmodule

// File: tb/test_jdc_decade_counter.sv
`timescale 1ns/1ps
module test_jdc_decade_counter;
  logic       clk = 1'b0;
  logic       rst_ni = 1'b1;
  logic       inhibit = 1'b0;
  logic [9:0] dec;
  logic       carry;

  int n_chk = 0;
  int n_fail = 0;
  int cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  jdc_decade_counter i_jdc_decade_counter (
    .clk_i    (clk),
    .rst_ni   (rst_ni),
    .inhibit_i(inhibit),
    .dec_o    (dec),
    .carry_o  (carry)
  );

  task automatic chk(input string req, input logic [9:0] got, input logic [9:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic chk_model(input string req);
    chk({req, " dec"}, dec, 10'(1) << cnt);
    chk("R5 carry", {9'd0, carry}, {9'd0, cnt < 5});
  endtask

  // drive at negedge, one rising edge, compare at the next negedge
  task automatic cyc(input logic inh, input string req);
    inhibit = inh;
    @(posedge clk);
    if (!inh) cnt = (cnt + 1) % 10;
    @(negedge clk);
    chk_model(req);
  endtask

  function automatic bit is_legal(input logic [4:0] p);
    logic [4:0] codes [10] = '{5'b00000, 5'b00001, 5'b00011, 5'b00111, 5'b01111,
                               5'b11111, 5'b11110, 5'b11100, 5'b11000, 5'b10000};
    foreach (codes[i]) if (codes[i] == p) return 1'b1;
    return 1'b0;
  endfunction

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    summary();
  end

  initial begin
    logic [9:0] held;
    #1 rst_ni = 1'b0;
    // R1: reset holds count zero through clocks, inhibit low and high
    repeat (2) @(negedge clk);
    inhibit = 1'b1;
    @(negedge clk);
    chk("R1 reset dec", dec, 10'h001);
    chk("R1 reset carry", {9'd0, carry}, 10'd1);
    inhibit = 1'b0;
    @(negedge clk);
    chk("R1 reset dec inhibit low", dec, 10'h001);
    rst_ni = 1'b1;
    cnt = 0;
    // R3 and R4: free count across a wrap
    for (int i = 0; i < 12; i++) cyc(1'b0, "R3 advance");
    // R2: inhibit holds
    for (int i = 0; i < 5; i++) cyc(1'b1, "R2 hold");
    // R4, R5: random inhibit over many revolutions
    for (int i = 0; i < 300; i++) cyc(1'($urandom_range(0, 1)), "R4 onehot");
    // R1: asynchronous reset between edges with counting enabled
    while (cnt != 7) cyc(1'b0, "R3 advance");
    #1 rst_ni = 1'b0;
    #0.5;
    chk("R1 async dec", dec, 10'h001);
    chk("R1 async carry", {9'd0, carry}, 10'd1);
    @(negedge clk);
    rst_ni = 1'b1;
    cnt = 0;
    cyc(1'b0, "R1 restart");
    // R6, R7, R2: every illegal code, held once then recovered
    for (int p = 0; p < 32; p++) begin
      if (is_legal(5'(p))) continue;
      inhibit = 1'b1;
      rst_ni = 1'b0;
      @(negedge clk);
      rst_ni = 1'b1;
      force i_jdc_decade_counter.u_ring.ring_q = 5'(p);
      #0.2;
      release i_jdc_decade_counter.u_ring.ring_q;
      #0.2;
      chk("R5 carry on illegal", {9'd0, carry}, {9'd0, ~p[4]});
      held = dec;
      @(posedge clk);
      @(negedge clk);
      chk("R2 hold illegal dec", dec, held);
      chk("R2 hold illegal carry", {9'd0, carry}, {9'd0, ~p[4]});
      inhibit = 1'b0;
      @(posedge clk);
      @(negedge clk);
      chk("R7 R6 recover dec", dec, 10'h001);
      chk("R7 recover carry", {9'd0, carry}, 10'd1);
      cnt = 0;
      cyc(1'b0, "R3 after recover");
    end
    summary();
  end
endmodule